// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffers

This block sits next to a direct-mapped cache that holds array data. It keeps a small set of FIFO buffers. Each buffer follows one sequential stream of cache lines and fetches lines ahead of use from the next memory level. Fetched lines stay in the buffers. They reach the cache only when the cache asks for them. Scalar traffic is passed through and never touches the buffers.

When the cache misses, it presents a line address and an array/scalar tag on the lookup port. Each buffer compares the address with its oldest line only, and all buffers compare at the same time.

- **Head hit:** the line is returned and the buffer advances by one line. The slot that was freed then requests the line after the last one the buffer asked for.
- **Miss in every buffer:** the buffer allocated longest ago is emptied and aimed at the missed line and the lines that follow it.

Fetches go to the next level one at a time. Buffers that have empty slots take turns in rotation.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset, `rsp_valid` and `mreq_valid` are low, `lk_ready` is high, and every buffer is empty, so the first array lookup misses.
- R2: A scalar lookup (`lk_array`=0) is accepted in the cycle it is presented. It gives a miss response, issues no fetch and changes no buffer. A later array lookup of a line that was a buffer head still hits.
- R3: An array lookup that matches no buffer head gives a miss response. The buffer chosen is the least recently allocated one, and allocation rotates 0,1,2,3,0... The chosen buffer drops its contents and requests lines A, A+1, ... A+DEPTH-1 in ascending order.
- R4: Only the head (oldest line) of a buffer is compared. A lookup of a line that the buffer holds behind its head is a miss.
- R5: An array lookup whose address equals a head with data present is accepted in that cycle. In the next cycle `rsp_valid`=1, `rsp_hit`=1 and the line appears on `rsp_data`. The buffer head moves to the next line, and the freed slot requests the line after the last one that buffer requested.
- R6: An array lookup that matches a head whose data has not yet returned holds `lk_ready` low until the data arrives. It is then accepted as a hit.
- R7: At most one next-level request is outstanding. `mreq_valid` stays low from a request handshake until `mrsp_valid` returns that request.
- R8: Buffers with free slots are granted next-level requests in round-robin order. Two buffers filling at the same time alternate line by line.
- R9: A buffer holds at most DEPTH lines. With no pops it stops requesting after DEPTH lines.
- R10: A response that returns for a buffer which was reallocated while the request was outstanding is discarded. It never appears as data of the new stream.
- R11: Data returned on a hit is exactly the line the next level supplied for that line address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Cache miss lookup presented |
| lk_array | input | 1 | Lookup is tagged as array/stream data (0 = scalar) |
| lk_addr | input | ADDR_W | Line address of the lookup |
| lk_ready | output | 1 | Lookup accepted this cycle (low while waiting for head data) |
| rsp_valid | output | 1 | Lookup result, one cycle after acceptance |
| rsp_hit | output | 1 | Result is a buffer hit |
| rsp_data | output | LINE_W | Line data on a hit |
| mreq_valid | output | 1 | Next-level line request |
| mreq_addr | output | ADDR_W | Requested line address |
| mreq_ready | input | 1 | Next level takes the request |
| mrsp_valid | input | 1 | Next level returns the outstanding line |
| mrsp_data | input | LINE_W | Returned line data |

## Verification
The bench reallocates a buffer while that buffer's fetch is still outstanding, then looks up the new head at once. A design that wrote the late response into the new stream would return the old line's data early. It looks up a line that sits behind a head; a design that searched whole buffers would report a hit. It presents a scalar lookup that equals a live head; a design that let scalars through would pop that head and make the later array lookup miss. Two buffers are filled at the same time to expose an arbiter that starves one of them. A lookup of a pending head is timed to expose a design that returns stale data instead of stalling.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_PASS,
    LK_HIT,
    LK_WAIT,
    LK_MISS
  } lk_kind_e;
endpackage

// File: rtl/spb_lane.sv
module spb_lane #(
  parameter int DEPTH  = 10,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512,
  localparam int SW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              pop_i,
  input  logic              issue_i,
  input  logic              fill_i,
  input  logic [SW-1:0]     fill_slot_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_valid_o,
  output logic [LINE_W-1:0] head_data_o,
  output logic              want_o,
  output logic [ADDR_W-1:0] want_addr_o,
  output logic [SW-1:0]     want_slot_o
);

  logic              active_q, active_d;
  logic [SW-1:0]     hptr_q, hptr_d;
  logic [ADDR_W-1:0] haddr_q, haddr_d;
  logic [CW-1:0]     issued_q, issued_d;
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [LINE_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     slot_sum;

  always_comb begin
    active_d = active_q;
    hptr_d   = hptr_q;
    haddr_d  = haddr_q;
    issued_d = issued_q;
    vld_d    = vld_q;
    if (alloc_i) begin
      active_d = 1'b1;
      hptr_d   = '0;
      haddr_d  = alloc_addr_i;
      issued_d = '0;
      vld_d    = '0;
    end else begin
      if (fill_i) vld_d[fill_slot_i] = 1'b1;
      if (pop_i) begin
        vld_d[hptr_q] = 1'b0;
        hptr_d  = (hptr_q == SW'(DEPTH - 1)) ? '0 : hptr_q + SW'(1);
        haddr_d = haddr_q + ADDR_W'(1);
      end
      case ({issue_i, pop_i})
        2'b10:   issued_d = issued_q + CW'(1);
        2'b01:   issued_d = issued_q - CW'(1);
        default: issued_d = issued_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hptr_q   <= '0;
      haddr_q  <= '0;
      issued_q <= '0;
      vld_q    <= '0;
    end else begin
      active_q <= active_d;
      hptr_q   <= hptr_d;
      haddr_q  <= haddr_d;
      issued_q <= issued_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i && !alloc_i) mem_q[fill_slot_i] <= fill_data_i;
  end

  assign slot_sum     = PW'(hptr_q) + PW'(issued_q);
  assign want_slot_o  = (slot_sum >= PW'(DEPTH)) ? SW'(slot_sum - PW'(DEPTH)) : SW'(slot_sum);
  assign want_addr_o  = haddr_q + ADDR_W'(issued_q);
  assign want_o       = active_q && (issued_q < CW'(DEPTH));
  assign active_o     = active_q;
  assign head_addr_o  = haddr_q;
  assign head_valid_o = vld_q[hptr_q];
  assign head_data_o  = mem_q[hptr_q];

  // R9
  issued_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q <= CW'(DEPTH));

  // R6
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (active_q && vld_q[hptr_q]));

  // R10
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !alloc_i) |-> !vld_q[fill_slot_i]);

  // R9
  issue_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (active_q && issued_q < CW'(DEPTH)));

endmodule

// File: rtl/spb_issue.sv
module spb_issue #(
  parameter int NB     = 4,
  parameter int ADDR_W = 26,
  parameter int SW     = 4,
  localparam int IW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     want_i,
  input  logic [ADDR_W-1:0] want_addr_i [NB],
  input  logic [SW-1:0]     want_slot_i [NB],
  input  logic [NB-1:0]     kill_i,
  input  logic              mreq_ready_i,
  input  logic              mrsp_valid_i,
  output logic [NB-1:0]     grant_o,
  output logic              mreq_valid_o,
  output logic [ADDR_W-1:0] mreq_addr_o,
  output logic [NB-1:0]     fill_o,
  output logic [SW-1:0]     fill_slot_o
);

  logic          busy_q, busy_d;
  logic          stale_q, stale_d;
  logic [IW-1:0] own_q, own_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [IW-1:0] rr_q, rr_d;
  logic [IW-1:0] pick;
  logic          found, fire, done;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NB; k++) begin
      int s;
      s = int'(rr_q) + k;
      if (s >= NB) s = s - NB;
      if (!found && want_i[s]) begin
        found = 1'b1;
        pick  = IW'(s);
      end
    end
  end

  assign mreq_valid_o = !busy_q && found;
  assign mreq_addr_o  = want_addr_i[pick];
  assign fire         = mreq_valid_o && mreq_ready_i;
  assign grant_o      = fire ? (NB'(1) << pick) : '0;
  assign done         = busy_q && mrsp_valid_i;
  assign fill_o       = (done && !stale_q && !kill_i[own_q]) ? (NB'(1) << own_q) : '0;
  assign fill_slot_o  = slot_q;

  always_comb begin
    busy_d  = busy_q;
    stale_d = stale_q;
    own_d   = own_q;
    slot_d  = slot_q;
    rr_d    = rr_q;
    if (fire) begin
      busy_d  = 1'b1;
      own_d   = pick;
      slot_d  = want_slot_i[pick];
      stale_d = kill_i[pick];
      rr_d    = (pick == IW'(NB - 1)) ? '0 : pick + IW'(1);
    end else if (done) begin
      busy_d  = 1'b0;
      stale_d = 1'b0;
    end else if (busy_q && kill_i[own_q]) begin
      stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      own_q   <= '0;
      slot_q  <= '0;
      rr_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      stale_q <= stale_d;
      own_q   <= own_d;
      slot_q  <= slot_d;
      rr_q    <= rr_d;
    end
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R8
  rr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && want_i[rr_q]) |-> grant_o[rr_q]);

  // R10
  kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kill_i[own_q]) |=> (!busy_q || stale_q));

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import spb_pkg::*;
#(
  parameter int NUM_BUF   = 4,
  parameter int BUF_DEPTH = 10,
  parameter int ADDR_W    = 26,
  parameter int LINE_W    = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_array,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              mreq_valid,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mreq_ready,
  input  logic              mrsp_valid,
  input  logic [LINE_W-1:0] mrsp_data
);

  localparam int SW = $clog2(BUF_DEPTH);
  localparam int IW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

  logic [NUM_BUF-1:0] act, hv, want, grant, fill, pop, alloc, match, hitv;
  logic [ADDR_W-1:0]  haddr [NUM_BUF];
  logic [ADDR_W-1:0]  waddr [NUM_BUF];
  logic [SW-1:0]      wslot [NUM_BUF];
  logic [LINE_W-1:0]  hdata [NUM_BUF];
  logic [SW-1:0]      fill_slot;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      aptr_q, aptr_d;
  lk_kind_e           kind;
  logic               rsp_valid_q, rsp_hit_q;
  logic [LINE_W-1:0]  rsp_data_q;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_lane
    spb_lane #(
      .DEPTH (BUF_DEPTH),
      .ADDR_W(ADDR_W),
      .LINE_W(LINE_W)
    ) i_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc[g]),
      .alloc_addr_i(lk_addr),
      .pop_i       (pop[g]),
      .issue_i     (grant[g]),
      .fill_i      (fill[g]),
      .fill_slot_i (fill_slot),
      .fill_data_i (mrsp_data),
      .active_o    (act[g]),
      .head_addr_o (haddr[g]),
      .head_valid_o(hv[g]),
      .head_data_o (hdata[g]),
      .want_o      (want[g]),
      .want_addr_o (waddr[g]),
      .want_slot_o (wslot[g])
    );
    assign match[g] = act[g] && (haddr[g] == lk_addr);
    assign hitv[g]  = match[g] && hv[g];
  end

  spb_issue #(
    .NB    (NUM_BUF),
    .ADDR_W(ADDR_W),
    .SW    (SW)
  ) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_i      (want),
    .want_addr_i (waddr),
    .want_slot_i (wslot),
    .kill_i      (alloc),
    .mreq_ready_i(mreq_ready),
    .mrsp_valid_i(mrsp_valid),
    .grant_o     (grant),
    .mreq_valid_o(mreq_valid),
    .mreq_addr_o (mreq_addr),
    .fill_o      (fill),
    .fill_slot_o (fill_slot)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hitv[i]) hit_idx = IW'(i);
    end
  end

  always_comb begin
    if (!lk_valid)      kind = LK_IDLE;
    else if (!lk_array) kind = LK_PASS;
    else if (|hitv)     kind = LK_HIT;
    else if (|match)    kind = LK_WAIT;
    else                kind = LK_MISS;
  end

  assign lk_ready = (kind != LK_WAIT);
  assign pop      = (kind == LK_HIT)  ? (NUM_BUF'(1) << hit_idx) : '0;
  assign alloc    = (kind == LK_MISS) ? (NUM_BUF'(1) << aptr_q)  : '0;
  assign aptr_d   = (kind != LK_MISS) ? aptr_q :
                    (aptr_q == IW'(NUM_BUF - 1)) ? '0 : aptr_q + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aptr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      aptr_q      <= aptr_d;
      rsp_valid_q <= (kind != LK_IDLE) && (kind != LK_WAIT);
      rsp_hit_q   <= (kind == LK_HIT);
    end
  end

  always_ff @(posedge clk) begin
    if (kind == LK_HIT) rsp_data_q <= hdata[hit_idx];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  // R7
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid);

  // R5
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && $past(lk_valid && lk_array)));

  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(lk_array)) |-> !rsp_hit);

  // R5
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

  // R6
  wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |-> (lk_valid && lk_array));

  // R3
  alloc_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|alloc && |pop));

endmodule

// File: tb/test_stream_prefetch_buf.sv
module test_stream_prefetch_buf;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int DEPTH = 10;
  localparam int ADDR_W = 26;
  localparam int LINE_W = 512;

  logic clk, rst_n;
  logic lk_valid, lk_array;
  logic [ADDR_W-1:0] lk_addr;
  logic lk_ready, rsp_valid, rsp_hit;
  logic [LINE_W-1:0] rsp_data;
  logic mreq_valid, mreq_ready, mrsp_valid;
  logic [ADDR_W-1:0] mreq_addr;
  logic [LINE_W-1:0] mrsp_data;

  stream_prefetch_buf #(.NUM_BUF(NB), .BUF_DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W))
  i_stream_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_array(lk_array), .lk_addr(lk_addr),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_ready(mreq_ready),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lat_cfg = 2;
  bit rnd_ready = 0;
  bit rnd_lat = 0;
  bit pend;
  int cnt;
  logic [ADDR_W-1:0] paddr;
  logic [ADDR_W-1:0] log_q [0:4095];
  int nlog;
  int r7_bad;

  function automatic logic [LINE_W-1:0] line_of(logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] r;
    for (int k = 0; k < LINE_W / 32; k++) r[k*32 +: 32] = 32'({a, 6'(k)});
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next-level memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; mrsp_valid <= 1'b0; mrsp_data <= '0; mreq_ready <= 1'b1;
      nlog <= 0; r7_bad <= 0; cnt <= 0; paddr <= '0;
    end else begin
      mrsp_valid <= 1'b0;
      if (pend) begin
        if (mreq_valid) r7_bad <= r7_bad + 1;
        if (cnt <= 1) begin
          mrsp_valid <= 1'b1; mrsp_data <= line_of(paddr); pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
      if (mreq_valid && mreq_ready) begin
        pend <= 1'b1; paddr <= mreq_addr;
        cnt <= rnd_lat ? 1 + int'($urandom % 5) : lat_cfg;
        log_q[nlog[11:0]] <= mreq_addr; nlog <= nlog + 1;
      end
      mreq_ready <= rnd_ready ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary_and_end();
    end
  end

  task automatic lookup(input logic [ADDR_W-1:0] a, input bit arr, output bit hit,
                        output logic [LINE_W-1:0] d, output int stalls, output bit rdy0);
    @(negedge clk);
    lk_valid = 1'b1; lk_array = arr; lk_addr = a; stalls = 0;
    #1 rdy0 = lk_ready;
    while (!lk_ready) begin
      @(negedge clk); #1; stalls++;
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; lk_array = 1'b0;
    check(rsp_valid === 1'b1, "R5", "response one cycle after accept", 64'(rsp_valid), 64'd1);
    hit = rsp_hit; d = rsp_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  logic [ADDR_W-1:0] mhead [NB];
  bit mact [NB];
  int mptr;
  logic [ADDR_W-1:0] spos [6];
  bit sused [6];

  initial begin
    bit hit, rdy;
    logic [LINE_W-1:0] d;
    int st, base;
    logic [ADDR_W-1:0] nextbase;
    void'($urandom(32'd20240611));
    lk_valid = 1'b0; lk_array = 1'b0; lk_addr = '0; rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(mreq_valid === 1'b0, "R1", "mreq_valid after reset", 64'(mreq_valid), 64'd0);
    check(lk_ready === 1'b1, "R1", "lk_ready after reset", 64'(lk_ready), 64'd1);

    // R2 scalar lookup passes through
    lookup(26'h50, 1'b0, hit, d, st, rdy);
    check(rdy == 1'b1 && st == 0, "R2", "scalar accepted at once", 64'(st), 64'd0);
    check(hit == 1'b0, "R2", "scalar hit", 64'(hit), 64'd0);
    wait_cyc(10);
    check(nlog == 0, "R2", "fetches after scalar", 64'(nlog), 64'd0);

    // R1 / R3 first array lookup misses and starts a stream
    lookup(26'h100, 1'b1, hit, d, st, rdy);
    check(hit == 1'b0, "R1", "first array lookup hit", 64'(hit), 64'd0);
    wait_cyc(80);
    check(nlog == DEPTH, "R9", "fetch count without pops", 64'(nlog), 64'(DEPTH));
    for (int k = 0; k < DEPTH; k++)
      check(log_q[k] == 26'h100 + 26'(k), "R3", "ascending fetch order", 64'(log_q[k]), 64'(26'h100 + k));

    // R5 head hit
    lookup(26'h100, 1'b1, hit, d, st, rdy);
    check(hit == 1'b1, "R5", "head hit", 64'(hit), 64'd1);
    check(d == line_of(26'h100), "R11", "hit data", d[63:0], line_of(26'h100) >> 0);
    wait_cyc(10);
    check(nlog == DEPTH + 1 && log_q[DEPTH] == 26'h10A, "R5", "refill after pop", 64'(log_q[DEPTH]), 64'h10A);

    // R2 scalar equal to a live head must not pop it
    lookup(26'h101, 1'b0, hit, d, st, rdy);
    check(hit == 1'b0, "R2", "scalar on live head", 64'(hit), 64'd0);

    // R4 behind-head line misses
    lookup(26'h102, 1'b1, hit, d, st, rdy);
    check(hit == 1'b0, "R4", "non-head line", 64'(hit), 64'd0);
    lookup(26'h101, 1'b1, hit, d, st, rdy);
    check(hit == 1'b1, "R2", "head kept after scalar", 64'(hit), 64'd1);
    check(d == line_of(26'h101), "R11", "hit data 0x101", d[63:0], line_of(26'h101) >> 0);
    wait_cyc(150);

    // R8 two streams alternate
    lat_cfg = 4;
    base = nlog;
    lookup(26'h300, 1'b1, hit, d, st, rdy);
    lookup(26'h400, 1'b1, hit, d, st, rdy);
    wait_cyc(150);
    for (int k = 0; k < 4; k++) begin
      check(log_q[base + 2*k] == 26'h300 + 26'(k), "R8", "even grant", 64'(log_q[base + 2*k]), 64'(26'h300 + k));
      check(log_q[base + 2*k + 1] == 26'h400 + 26'(k), "R8", "odd grant", 64'(log_q[base + 2*k + 1]), 64'(26'h400 + k));
    end

    // R6 stall on pending head
    lat_cfg = 8;
    lookup(26'h500, 1'b1, hit, d, st, rdy);
    lookup(26'h500, 1'b1, hit, d, st, rdy);
    check(rdy == 1'b0 && st > 0, "R6", "stall on pending head", 64'(st), 64'd1);
    check(hit == 1'b1, "R6", "hit after stall", 64'(hit), 64'd1);
    check(d == line_of(26'h500), "R11", "hit data 0x500", d[63:0], line_of(26'h500) >> 0);
    wait_cyc(200);

    // R10 late response for a reallocated buffer
    lat_cfg = 30;
    lookup(26'h600, 1'b1, hit, d, st, rdy);
    lookup(26'h700, 1'b1, hit, d, st, rdy);
    lookup(26'h800, 1'b1, hit, d, st, rdy);
    lookup(26'h900, 1'b1, hit, d, st, rdy);
    lookup(26'hA00, 1'b1, hit, d, st, rdy);
    lookup(26'hA00, 1'b1, hit, d, st, rdy);
    check(hit == 1'b1, "R10", "new stream head hit", 64'(hit), 64'd1);
    check(d == line_of(26'hA00), "R10", "no stale data", d[63:0], line_of(26'hA00) >> 0);
    check(r7_bad == 0, "R7", "requests while outstanding", 64'(r7_bad), 64'd0);

    // random phase against a head model
    do_reset();
    rnd_ready = 1; rnd_lat = 1;
    mptr = 0; nextbase = 26'h10000;
    for (int i = 0; i < NB; i++) begin mact[i] = 0; mhead[i] = '0; end
    for (int i = 0; i < 6; i++) sused[i] = 0;
    for (int it = 0; it < 300; it++) begin
      int r, s, ei;
      logic [ADDR_W-1:0] a;
      r = int'($urandom % 100);
      if (r < 15) begin
        a = 26'($urandom);
        lookup(a, 1'b0, hit, d, st, rdy);
        check(hit == 1'b0, "R2", "random scalar", 64'(hit), 64'd0);
      end else begin
        s = int'($urandom % 6);
        if (r < 30 || !sused[s]) begin
          spos[s] = nextbase; nextbase = nextbase + 26'h1000; sused[s] = 1;
        end else if (r < 38) spos[s] = spos[s] + 26'd2;
        a = spos[s];
        ei = -1;
        for (int i = 0; i < NB; i++) if (mact[i] && mhead[i] == a) ei = i;
        lookup(a, 1'b1, hit, d, st, rdy);
        check(hit == (ei >= 0), "R3", "random hit/miss", 64'(hit), 64'(ei >= 0));
        if (ei >= 0) begin
          check(d == line_of(a), "R11", "random hit data", d[63:0], line_of(a) >> 0);
          mhead[ei] = mhead[ei] + 26'd1;
        end else begin
          mact[mptr] = 1; mhead[mptr] = a; mptr = (mptr + 1) % NB;
        end
        spos[s] = spos[s] + 26'd1;
      end
    end
    wait_cyc(20);
    check(r7_bad == 0, "R7", "single outstanding request", 64'(r7_bad), 64'd0);
    summary_and_end();
  end
endmodule